// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Dead Time

This block drives three motor phases from one shared up-counter. Each phase has a high-side pin and a low-side pin. The high-side pin is active from the start of each PWM period until the counter reaches that phase's compare value. The low-side pin becomes active at a second threshold and stays active to the end of the period. The second threshold is the compare value plus a dead-time offset, saturated at the period length.

The low-side threshold is always the high-side edge plus the dead time, so the gap between the high-side turning off and the low-side turning on is the same for rising and for falling duty. The threshold never lands earlier than the high-side edge, so the two pins of a phase never overlap.

The period, the dead time and the three compare values are plain level inputs. The block samples them once per period, on the last count before the wrap. A host or transfer engine sees a one-cycle request strobe per phase at the start of every period. That is its cue to place the next values on the inputs before the period ends. There is no handshake and no back-pressure: whatever is on the inputs at the wrap is taken.

Top module: `pwm3_dead`

## Requirements
- R1: The counter starts at 0 and counts up by one per clock. After the value P-1 it returns to 0, where P is the period that was sampled at the previous wrap.
- R2: A period input below 2 is used as a period of 2.
- R3: A phase's high-side output is 1 while the count is below that phase's sampled compare value C, and 0 otherwise. C = 0 gives a constant 0; C >= P gives a constant 1 across the wrap.
- R4: A phase's low-side output is 1 while the count is at or above L, where L = min(C + D, P) and D is the sampled dead time. When C + D >= P, the low-side output stays 0 for the whole period.
- R5: When C + D < P, the low-side output rises exactly D cycles after the high-side output falls. This holds both when C has just grown and when C has just shrunk.
- R6: The high-side and low-side outputs of one phase are never 1 in the same cycle.
- R7: The period, dead-time and compare inputs are sampled only on the clock edge that ends a period (count P-1). Changes to them at any other time have no effect on the running period.
- R8: Each phase's request output pulses for exactly one cycle, in the cycle where the count is 0, once per period.
- R9: After reset the block runs with P = 10, C = 5 for every phase and D = 10. In that first period the high-side outputs are 1 for counts 0 to 4 and the low-side outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | CW | Period length in clock cycles, sampled at wrap |
| cmp_i | input | NPH x CW | Per-phase high-side compare values, sampled at wrap (index 0 = U, 1 = V, 2 = W) |
| dead_i | input | CW | Dead time in clock cycles, sampled at wrap |
| req_o | output | NPH | Per-phase request strobe at count 0 |
| hi_o | output | NPH | High-side pin per phase, 1 = active |
| lo_o | output | NPH | Low-side pin per phase, 1 = active |

## Verification
The embedded properties assume that the counter and the shadow registers change only at the wrap. They also assume that the clamped period is at least 2, so a request strobe can never last two cycles. The stimulus respects this:
- It changes inputs only on falling clock edges.
- It uses periods of 2 or more once clamping is applied, including the clamped 0 and 1 cases.
- It keeps C + D within CW + 1 bits.

Inputs are rewritten mid-period on purpose to show they are ignored until the wrap.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  // Smallest period the counter will run with; shorter requests are raised to this.
  localparam int unsigned MIN_PERIOD = 2;
  // Phase indices, used to name the per-phase generate instances.
  typedef enum int unsigned {PH_U = 0, PH_V = 1, PH_W = 2} phase_e;
endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
  import pwm3_pkg::*;
#(
  parameter int unsigned CW         = 16,
  parameter int unsigned DEF_PERIOD = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] per_o,
  output logic [CW-1:0] per_nx_o,
  output logic          wrap_o,
  output logic          start_o
);
  localparam logic [CW-1:0] MINP = CW'(MIN_PERIOD);
  localparam logic [CW-1:0] DEFP = CW'(DEF_PERIOD);

  logic [CW-1:0] cnt_q, per_q;

  // Periods below the minimum are raised to the minimum.
  assign per_nx_o = (period_i < MINP) ? MINP : period_i;
  assign wrap_o   = (cnt_q == per_q - 1'b1);
  assign start_o  = (cnt_q == '0);
  assign cnt_o    = cnt_q;
  assign per_o    = per_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= DEFP;
    end else if (wrap_o) begin
      cnt_q <= '0;
      per_q <= per_nx_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_q < per_q); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) wrap_o |=> cnt_q == '0); // R1
  AST_PER_MIN:   assert property (@(posedge clk) disable iff (!rst_n) per_q >= MINP); // R2
endmodule

// File: rtl/pwm3_dead_sum.sv
module pwm3_dead_sum #(
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0] base_i,
  input  logic [CW-1:0] dead_i,
  input  logic [CW-1:0] limit_i,
  output logic [CW-1:0] sum_o
);
  logic [CW:0] wide;

  // The sum is one bit wider so it cannot wrap; the result saturates at the limit.
  always_comb begin
    wide = {1'b0, base_i} + {1'b0, dead_i};
    if (wide > {1'b0, limit_i}) sum_o = limit_i;
    else                        sum_o = wide[CW-1:0];
  end
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
  parameter int unsigned CW         = 16,
  parameter int unsigned INIT_CMP   = 5,
  parameter int unsigned DEF_PERIOD = 10,
  parameter int unsigned DEF_DEAD   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrap_i,
  input  logic          start_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] per_nx_i,
  input  logic [CW-1:0] cmp_i,
  input  logic [CW-1:0] dead_i,
  output logic          hi_o,
  output logic          lo_o,
  output logic          req_o
);
  localparam int unsigned RST_SUM = INIT_CMP + DEF_DEAD;
  localparam int unsigned RST_LO  = (RST_SUM > DEF_PERIOD) ? DEF_PERIOD : RST_SUM;

  logic [CW-1:0] hi_sh, lo_sh, lo_nx;

  pwm3_dead_sum #(.CW(CW)) u_sum (
    .base_i (cmp_i),
    .dead_i (dead_i),
    .limit_i(per_nx_i),
    .sum_o  (lo_nx)
  );

  // Shadow thresholds are reloaded only at the wrap.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_sh <= CW'(INIT_CMP);
      lo_sh <= CW'(RST_LO);
    end else if (wrap_i) begin
      hi_sh <= cmp_i;
      lo_sh <= lo_nx;
    end
  end

  assign hi_o  = (cnt_i < hi_sh);
  assign lo_o  = (cnt_i >= lo_sh);
  assign req_o = start_i;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(hi_o && lo_o)); // R6
  AST_LO_ORDER:   assert property (@(posedge clk) disable iff (!rst_n) (lo_sh >= hi_sh) || (lo_sh == per_i)); // R5
  AST_LO_SAT:     assert property (@(posedge clk) disable iff (!rst_n) lo_sh <= per_i); // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                     !wrap_i |=> ($stable(hi_sh) && $stable(lo_sh))); // R7
  AST_REQ_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) req_o |=> !req_o); // R8
endmodule

// File: rtl/pwm3_dead.sv
module pwm3_dead
  import pwm3_pkg::*;
#(
  parameter int unsigned CW         = 16,
  parameter int unsigned NPH        = 3,
  parameter int unsigned DEF_PERIOD = 10,
  parameter int unsigned DEF_DEAD   = 10,
  parameter int unsigned INIT_CMP   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CW-1:0]           period_i,
  input  logic [NPH-1:0][CW-1:0]  cmp_i,
  input  logic [CW-1:0]           dead_i,
  output logic [NPH-1:0]          req_o,
  output logic [NPH-1:0]          hi_o,
  output logic [NPH-1:0]          lo_o
);
  logic [CW-1:0] cnt, per, per_nx;
  logic          wrap, start;

  pwm3_timebase #(.CW(CW), .DEF_PERIOD(DEF_PERIOD)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .period_i(period_i),
    .cnt_o   (cnt),
    .per_o   (per),
    .per_nx_o(per_nx),
    .wrap_o  (wrap),
    .start_o (start)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    pwm3_phase #(
      .CW(CW), .INIT_CMP(INIT_CMP), .DEF_PERIOD(DEF_PERIOD), .DEF_DEAD(DEF_DEAD)
    ) u_ph (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap_i  (wrap),
      .start_i (start),
      .cnt_i   (cnt),
      .per_i   (per),
      .per_nx_i(per_nx),
      .cmp_i   (cmp_i[p]),
      .dead_i  (dead_i),
      .hi_o    (hi_o[p]),
      .lo_o    (lo_o[p]),
      .req_o   (req_o[p])
    );
  end

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) req_o[0] |-> cnt == '0); // R8
endmodule

// File: tb/tb_pwm3_dead.sv
module tb_pwm3_dead;
  localparam int CW  = 16;
  localparam int NPH = 3;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [CW-1:0]          period_i;
  logic [NPH-1:0][CW-1:0] cmp_i;
  logic [CW-1:0]          dead_i;
  logic [NPH-1:0]         req_o, hi_o, lo_o;

  int n_tests = 0;
  int n_fail  = 0;
  int overlap_cnt = 0;
  int chg_at = -1;
  int chg_p, chg_c, chg_d;
  bit cap_hi [NPH][64];
  bit cap_lo [NPH][64];

  always #4 clk = ~clk;

  pwm3_dead #(.CW(CW), .NPH(NPH)) dut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .cmp_i(cmp_i),
    .dead_i(dead_i), .req_o(req_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  // R6 monitor: watch every cycle after reset
  always @(negedge clk)
    if (rst_n)
      for (int p = 0; p < NPH; p++)
        if (hi_o[p] && lo_o[p]) overlap_cnt++;

  task automatic set_in(input int P, input int c0, input int c1, input int c2, input int D);
    period_i = CW'(P); cmp_i[0] = CW'(c0); cmp_i[1] = CW'(c1); cmp_i[2] = CW'(c2); dead_i = CW'(D);
  endtask

  task automatic sync_start();
    @(negedge clk);
    while (!req_o[0]) @(negedge clk);
  endtask

  // Capture one full period and compare every phase against the requirement model.
  task automatic capture(input int P, input int c0, input int c1, input int c2,
                         input int D, input string tag, input bit do_sync);
    int c[NPH];
    bit bad[NPH];
    string msg[NPH];
    c[0] = c0; c[1] = c1; c[2] = c2;
    if (do_sync) sync_start();
    for (int p = 0; p < NPH; p++) bad[p] = 0;
    for (int i = 0; i < P; i++) begin
      if (i > 0) @(negedge clk);
      if (i == chg_at) set_in(chg_p, chg_c, chg_c, chg_c, chg_d);
      for (int p = 0; p < NPH; p++) begin
        int lth;
        bit eh, el, er;
        lth = (c[p] + D > P) ? P : c[p] + D;
        eh = (i < c[p]);
        el = (i >= lth);
        er = (i == 0);
        cap_hi[p][i] = hi_o[p];
        cap_lo[p][i] = lo_o[p];
        if (!bad[p] && (hi_o[p] !== eh || lo_o[p] !== el || req_o[p] !== er)) begin
          bad[p] = 1;
          $sformat(msg[p], "FAIL %s phase %0d count %0d: hi/lo/req actual %b%b%b expected %b%b%b",
                   tag, p, i, hi_o[p], lo_o[p], req_o[p], eh, el, er);
        end
      end
    end
    chg_at = -1;
    for (int p = 0; p < NPH; p++) begin
      n_tests++;
      if (bad[p]) begin n_fail++; $display("%s", msg[p]); end
    end
  endtask

  // R5: measured distance from high-side fall to low-side rise on phase 0
  task automatic check_gap(input int P, input int D, input string tag);
    int fall, rise;
    fall = -1; rise = -1;
    for (int i = 0; i < P; i++) begin
      if (fall < 0 && !cap_hi[0][i]) fall = i;
      if (rise < 0 && cap_lo[0][i]) rise = i;
    end
    n_tests++;
    if (fall < 0 || rise - fall != D) begin
      n_fail++;
      $display("FAIL %s gap actual %0d expected %0d", tag, rise - fall, D);
    end
  endtask

  task automatic t_reset();
    set_in(16, 2, 7, 9, 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    capture(10, 5, 5, 5, 10, "R9 reset values", 0);
    capture(16, 2, 7, 9, 3, "R1 new period after wrap", 1);
  endtask

  task automatic t_phases();
    set_in(10, 2, 5, 7, 2);
    capture(10, 2, 5, 7, 2, "R3 R4 distinct phases", 1);
  endtask

  task automatic t_gap_dir();
    set_in(20, 6, 6, 6, 4);
    capture(20, 6, 6, 6, 4, "R5 base", 1);
    set_in(20, 12, 12, 12, 4);
    capture(20, 12, 12, 12, 4, "R5 rising duty", 1);
    check_gap(20, 4, "R5 rising duty");
    set_in(20, 3, 3, 3, 4);
    capture(20, 3, 3, 3, 4, "R5 falling duty", 1);
    check_gap(20, 4, "R5 falling duty");
  endtask

  task automatic t_edges();
    set_in(10, 0, 10, 4, 3);
    capture(10, 0, 10, 4, 3, "R3 zero and full duty", 1);
    set_in(10, 12, 0, 4, 5);
    capture(10, 12, 0, 4, 5, "R4 boundary C+D=P-1", 1);
    set_in(10, 8, 5, 9, 5);
    capture(10, 8, 5, 9, 5, "R4 saturation", 1);
  endtask

  task automatic t_ignore_mid();
    set_in(12, 6, 6, 6, 2);
    capture(12, 6, 6, 6, 2, "R7 setup", 1);
    chg_at = 3; chg_p = 8; chg_c = 10; chg_d = 0;
    capture(12, 6, 6, 6, 2, "R7 mid-period change ignored", 1);
    capture(8, 10, 10, 10, 0, "R7 change taken at wrap", 1);
  endtask

  task automatic t_min_period();
    set_in(0, 1, 1, 0, 0);
    capture(2, 1, 1, 0, 0, "R2 period 0 raised", 1);
    set_in(1, 1, 2, 0, 1);
    capture(2, 1, 2, 0, 1, "R2 period 1 raised", 1);
    capture(2, 1, 2, 0, 1, "R8 consecutive short periods", 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_phases();
    t_gap_dir();
    t_edges();
    t_ignore_mid();
    t_min_period();
    n_tests++;
    if (overlap_cnt != 0) begin
      n_fail++;
      $display("FAIL R6 overlap cycles actual %0d expected 0", overlap_cnt);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule